// File: doc/BRIEF.md
# Bitonic Pass Partition Address Generator

This block drives the memory side of a bitonic sorting network that runs over `N = 2^n` items held in a large memory. A small local buffer can hold `2^SH` items at a time. The block groups the network's compare-exchange steps into passes, and each pass is chosen so that it can be completed entirely inside that buffer. For each pass it lists the disjoint partitions of the item space. For each partition it emits the global addresses of the items to load, one address per handshake beat.

The steps are numbered by a global index `k`. Stages `s` run from 1 to `n`, and inside stage `s` the distance exponent `c` falls from `s-1` to 0. The partner of address `r` at a step is `r XOR 2^c`. Every pass has a set of offset bit positions: first all distances its steps use, then the lowest unused positions below `n` until there are `min(n,SH)` positions. The local offset is spread over those positions in ascending order. The partition index fills the remaining positions below `n` in ascending order. The result is one contiguous field when a pass stays inside one stage, and a split field when it crosses a stage boundary. Either way, both partners of every step in the pass fall in the same partition.

Pulse `start` with the size exponent set. Accept beats with `outReady`. `done` goes high after the last beat of the last pass.

Top module: `bitonic_part_addr`

## Requirements
- R1: After reset `outValid` and `done` are 0.
- R2: Step order is `k = 0, 1, ...` over stages `s = 1..n`, with `c` falling from `s-1` to 0. Let `T = n(n+1)/2` and `F = SH(SH+1)/2`. Pass 0 covers steps 0 to `min(T,F)-1`; when `n <= SH` that range ends at `T-1`. Pass `p >= 1` covers steps `F+(p-1)SH` to `min(F+p*SH, T)-1`. `stepFirst` and `stepLast` report this range for every beat.
- R3: The number of passes, counted by `passNum` from 0, is 1 when `n <= SH` and `1 + ceil((T-F)/SH)` otherwise.
- R4: Each pass emits `2^n` beats, and each address in `0..2^n-1` appears exactly once.
- R5: For every step `c` in a pass, each address `r` and `r XOR 2^c` carry the same `partIdx` in that pass.
- R6: Beats come in order with `partIdx` outer and `localOff` inner, both ascending from 0. `localOff` counts to `2^min(n,SH)-1` and `partIdx` counts to `2^(n-min(n,SH))-1`.
- R7: `outAddr` bits at or above `n` are 0. The offset positions are the distances of the pass's steps plus the lowest unused positions below `n`, up to `min(n,SH)` positions in total. `localOff` bits go into the offset positions in ascending order, and `partIdx` bits go into the other positions below `n` in ascending order. When `n <= SH` this makes `outAddr == localOff`.
- R8: While `outValid` is 1 and `outReady` is 0, every output holds its value.
- R9: After the last beat, `done` is 1 and `outValid` is 0 until the next `start`, which begins a new run with a new size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, sampled while idle or done |
| sizeExp | input | NEXP_W | Size exponent n, 1..ADDR_W |
| outReady | input | 1 | Downstream accepts the current beat |
| outValid | output | 1 | Beat is valid |
| outAddr | output | ADDR_W | Global item address |
| partIdx | output | ADDR_W-SH | Partition index within the pass |
| localOff | output | SH | Offset inside the partition |
| passNum | output | STEP_W | Pass number |
| stepFirst | output | STEP_W | First global step of the pass |
| stepLast | output | STEP_W | Last global step of the pass |
| done | output | 1 | All passes finished |

## Verification
The hardest case to reach is a pass whose steps span two stages. Its offset field then splits into a low part and a high part, and any padding bits must go into the right gaps. Only sizes well above `SH` produce several such passes. The stimulus therefore runs a scaled configuration (`SH = 3`, address width 8) over every size from 1 to 8, so that single-stage, crossing and single-pass runs all occur. A pseudo-random `outReady` pattern stalls beats in the middle of partitions and at pass boundaries.

// File: rtl/bitonic_seq_pkg.sv
package bitonic_seq_pkg;

  // Strobes from the pass controller to the address datapath.
  typedef struct packed {
    logic clrMask;   // start a new offset-position set
    logic setBit;    // add the distance in bitPos to the set
    logic padMask;   // fill the set up to its full width
    logic clrCount;  // rewind partition and offset counters
    logic advance;   // one beat accepted downstream
  } pathCtl_t;

endpackage

// File: rtl/bitonic_pass_ctrl.sv
module bitonic_pass_ctrl
  import bitonic_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SH     = 12,
  parameter int NEXP_W = $clog2(ADDR_W + 2),
  parameter int STEP_W = $clog2(ADDR_W * (ADDR_W + 1) / 2 + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [NEXP_W-1:0] sizeExp,
  input  logic              outReady,
  input  logic              lastBeat,
  output pathCtl_t          ctl,
  output logic [NEXP_W-1:0] bitPos,
  output logic [NEXP_W-1:0] nCur,
  output logic              outValid,
  output logic              done,
  output logic [STEP_W-1:0] passNum,
  output logic [STEP_W-1:0] stepFirst,
  output logic [STEP_W-1:0] stepLast
);

  localparam int WALK_W = $clog2(SH + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_EMIT, ST_FIN} state_t;

  state_t            state;
  logic [NEXP_W-1:0] nReg;
  logic [NEXP_W-1:0] sCur;
  logic [NEXP_W-1:0] cCur;
  logic [STEP_W-1:0] kCur;
  logic [WALK_W-1:0] walked;
  logic [STEP_W-1:0] passReg;
  logic [STEP_W-1:0] firstReg;
  logic [STEP_W-1:0] lastReg;
  logic              stepsLeft;
  logic              canStep;

  assign stepsLeft = 32'(sCur) <= 32'(nReg);
  assign canStep   = stepsLeft &&
                     ((passReg == '0) ? (32'(sCur) <= SH) : (32'(walked) < SH));

  always_comb begin
    ctl    = '0;
    bitPos = cCur;
    unique case (state)
      ST_IDLE, ST_FIN: ctl.clrMask = start;
      ST_WALK: begin
        if (canStep) begin
          ctl.setBit = 1'b1;
        end else begin
          ctl.padMask  = 1'b1;
          ctl.clrCount = 1'b1;
        end
      end
      ST_EMIT: begin
        ctl.advance = outReady;
        ctl.clrMask = outReady && lastBeat && stepsLeft;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      nReg     <= '0;
      sCur     <= '0;
      cCur     <= '0;
      kCur     <= '0;
      walked   <= '0;
      passReg  <= '0;
      firstReg <= '0;
      lastReg  <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_FIN: begin
          if (start) begin
            nReg     <= sizeExp;
            sCur     <= NEXP_W'(1);
            cCur     <= '0;
            kCur     <= '0;
            walked   <= '0;
            passReg  <= '0;
            firstReg <= '0;
            state    <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (canStep) begin
            kCur    <= kCur + 1'b1;
            walked  <= walked + 1'b1;
            lastReg <= kCur;
            if (cCur == '0) begin
              sCur <= sCur + 1'b1;
              cCur <= sCur;
            end else begin
              cCur <= cCur - 1'b1;
            end
          end else begin
            state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (outReady && lastBeat) begin
            if (stepsLeft) begin
              passReg  <= passReg + 1'b1;
              walked   <= '0;
              firstReg <= kCur;
              state    <= ST_WALK;
            end else begin
              state <= ST_FIN;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign nCur      = nReg;
  assign outValid  = state == ST_EMIT;
  assign done      = state == ST_FIN;
  assign passNum   = passReg;
  assign stepFirst = firstReg;
  assign stepLast  = lastReg;

  // R2: a reported step range is never empty
  a_r2_range_order: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> stepLast >= stepFirst);

  // R2: passes after the first cover at most SH steps
  a_r2_later_len: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && passNum != '0) |-> (32'(stepLast - stepFirst) < SH));

  // R9: no beats offered once finished
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

endmodule

// File: rtl/bitonic_addr_path.sv
module bitonic_addr_path
  import bitonic_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SH     = 12,
  parameter int NEXP_W = $clog2(ADDR_W + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pathCtl_t             ctl,
  input  logic [NEXP_W-1:0]    bitPos,
  input  logic [NEXP_W-1:0]    nCur,
  input  logic                 outValid,
  output logic [ADDR_W-SH-1:0] partIdx,
  output logic [SH-1:0]        localOff,
  output logic [ADDR_W-1:0]    outAddr,
  output logic                 lastBeat
);

  localparam int PART_W = ADDR_W - SH;
  localparam int CNT_W  = $clog2(SH + 1);

  logic [ADDR_W-1:0] maskReg;
  logic [ADDR_W-1:0] maskPad;
  logic [ADDR_W-1:0] nMask;
  logic [SH-1:0]     offCnt;
  logic [PART_W-1:0] partCnt;
  logic [CNT_W-1:0]  effSh;
  logic [NEXP_W-1:0] partBits;
  logic [SH:0]       offMax;
  logic [PART_W:0]   partMax;
  logic              offWrap;

  assign effSh    = (32'(nCur) < SH) ? CNT_W'(nCur) : CNT_W'(SH);
  assign partBits = nCur - NEXP_W'(effSh);
  assign offMax   = ((SH + 1)'(1) << effSh) - 1'b1;
  assign partMax  = ((PART_W + 1)'(1) << partBits) - 1'b1;
  assign offWrap  = {1'b0, offCnt} == offMax;
  assign lastBeat = offWrap && ({1'b0, partCnt} == partMax);

  always_comb begin
    for (int i = 0; i < ADDR_W; i++) nMask[i] = i < int'(nCur);
  end

  // Fill the lowest unused positions below n until effSh positions are set.
  always_comb begin
    int cnt;
    cnt     = $countones(maskReg);
    maskPad = maskReg;
    for (int i = 0; i < ADDR_W; i++) begin
      if (nMask[i] && !maskReg[i] && cnt < int'(effSh)) begin
        maskPad[i] = 1'b1;
        cnt++;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      offCnt  <= '0;
      partCnt <= '0;
    end else begin
      if (ctl.clrMask)      maskReg <= '0;
      else if (ctl.setBit)  maskReg <= maskReg | (ADDR_W'(1) << bitPos);
      else if (ctl.padMask) maskReg <= maskPad;

      if (ctl.clrCount) begin
        offCnt  <= '0;
        partCnt <= '0;
      end else if (ctl.advance) begin
        if (offWrap) begin
          offCnt  <= '0;
          partCnt <= partCnt + 1'b1;
        end else begin
          offCnt <= offCnt + 1'b1;
        end
      end
    end
  end

  // Spread offset bits over the mask positions and partition bits over the rest.
  always_comb begin
    int io;
    int ip;
    io      = 0;
    ip      = 0;
    outAddr = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (nMask[i]) begin
        if (maskReg[i]) begin
          if (io < SH) outAddr[i] = offCnt[io];
          io++;
        end else begin
          if (ip < PART_W) outAddr[i] = partCnt[ip];
          ip++;
        end
      end
    end
  end

  assign partIdx  = partCnt;
  assign localOff = offCnt;

  // R7: the offset position set has exactly min(n,SH) positions, all below n
  a_r7_mask_width: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(maskReg) == int'(effSh)) && ((maskReg & ~nMask) == '0));

  // R6: offset is the inner counter
  a_r6_inner_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !offWrap && !ctl.clrCount) |=>
      (offCnt == $past(offCnt) + 1'b1) && (partCnt == $past(partCnt)));

  // R6: partition index advances only when the offset wraps
  a_r6_outer_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && offWrap && !lastBeat && !ctl.clrCount) |=>
      (offCnt == '0) && (partCnt == $past(partCnt) + 1'b1));

endmodule

// File: rtl/bitonic_part_addr.sv
module bitonic_part_addr
  import bitonic_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SH     = 12,
  parameter int NEXP_W = $clog2(ADDR_W + 2),
  parameter int STEP_W = $clog2(ADDR_W * (ADDR_W + 1) / 2 + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [NEXP_W-1:0]    sizeExp,
  input  logic                 outReady,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    outAddr,
  output logic [ADDR_W-SH-1:0] partIdx,
  output logic [SH-1:0]        localOff,
  output logic [STEP_W-1:0]    passNum,
  output logic [STEP_W-1:0]    stepFirst,
  output logic [STEP_W-1:0]    stepLast,
  output logic                 done
);

  pathCtl_t          ctl;
  logic [NEXP_W-1:0] bitPos;
  logic [NEXP_W-1:0] nCur;
  logic              lastBeat;

  bitonic_pass_ctrl #(
    .ADDR_W(ADDR_W), .SH(SH), .NEXP_W(NEXP_W), .STEP_W(STEP_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .sizeExp(sizeExp),
    .outReady(outReady), .lastBeat(lastBeat), .ctl(ctl), .bitPos(bitPos),
    .nCur(nCur), .outValid(outValid), .done(done), .passNum(passNum),
    .stepFirst(stepFirst), .stepLast(stepLast)
  );

  bitonic_addr_path #(
    .ADDR_W(ADDR_W), .SH(SH), .NEXP_W(NEXP_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitPos(bitPos), .nCur(nCur),
    .outValid(outValid), .partIdx(partIdx), .localOff(localOff),
    .outAddr(outAddr), .lastBeat(lastBeat)
  );

  // R8: a stalled beat holds every output
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outAddr) && $stable(partIdx) &&
      $stable(localOff) && $stable(passNum) && $stable(stepFirst) && $stable(stepLast));

endmodule

// File: tb/sim_bitonic_part_addr.sv
`timescale 1ns/100ps
module sim_bitonic_part_addr;

  localparam int ADDR_W = 8;
  localparam int SH     = 3;
  localparam int NEXP_W = $clog2(ADDR_W + 2);
  localparam int STEP_W = $clog2(ADDR_W * (ADDR_W + 1) / 2 + 1);
  localparam int NRUN   = 9;
  // each vector: size exponent, expected pass count, ready mode (0 random, 1 always)
  localparam int RUN_N[NRUN]    = '{8, 3, 1, 4, 5, 6, 7, 2, 8};
  localparam int RUN_PASS[NRUN] = '{11, 1, 1, 3, 4, 6, 9, 1, 11};
  localparam int RUN_RDY[NRUN]  = '{0, 0, 0, 0, 0, 0, 0, 0, 1};

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 start = 1'b0;
  logic [NEXP_W-1:0]    sizeExp = '0;
  logic                 outReady = 1'b0;
  logic                 outValid;
  logic [ADDR_W-1:0]    outAddr;
  logic [ADDR_W-SH-1:0] partIdx;
  logic [SH-1:0]        localOff;
  logic [STEP_W-1:0]    passNum;
  logic [STEP_W-1:0]    stepFirst;
  logic [STEP_W-1:0]    stepLast;
  logic                 done;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  bitonic_part_addr #(.ADDR_W(ADDR_W), .SH(SH)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .sizeExp(sizeExp),
    .outReady(outReady), .outValid(outValid), .outAddr(outAddr),
    .partIdx(partIdx), .localOff(localOff), .passNum(passNum),
    .stepFirst(stepFirst), .stepLast(stepLast), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int stepDist(input int k);
    int s = 1;
    int c = 0;
    for (int j = 0; j < k; j++) begin
      if (c == 0) begin c = s; s++; end
      else c--;
    end
    return c;
  endfunction

  function automatic int firstStep(input int n, input int p);
    int f = SH * (SH + 1) / 2;
    return (p == 0) ? 0 : f + (p - 1) * SH;
  endfunction

  function automatic int lastStep(input int n, input int p);
    int t = n * (n + 1) / 2;
    int f = SH * (SH + 1) / 2;
    int e;
    if (p == 0) e = (n <= SH) ? t : f;
    else e = f + p * SH;
    if (e > t) e = t;
    return e - 1;
  endfunction

  function automatic int passMask(input int n, input int p);
    int m = 0;
    int cnt = 0;
    int w = (n < SH) ? n : SH;
    for (int k = firstStep(n, p); k <= lastStep(n, p); k++) m |= 1 << stepDist(k);
    for (int i = 0; i < n; i++) if ((m >> i) & 1) cnt++;
    for (int i = 0; i < n; i++)
      if (!((m >> i) & 1) && cnt < w) begin m |= 1 << i; cnt++; end
    return m;
  endfunction

  function automatic int spread(input int n, input int m, input int part, input int off);
    int io = 0;
    int ip = 0;
    int r = 0;
    for (int i = 0; i < n; i++) begin
      if ((m >> i) & 1) begin r |= ((off >> io) & 1) << i; io++; end
      else begin r |= ((part >> ip) & 1) << i; ip++; end
    end
    return r;
  endfunction

  task automatic runOne(input int n, input int expPass, input int rdyMode);
    bit seen[256];
    int partOf[256];
    int beat = 0;
    int pass = 0;
    int w = (n < SH) ? n : SH;
    int items = 1 << n;
    int m = passMask(n, 0);
    bit prevStall = 0;
    int pAddr = 0, pPart = 0, pOff = 0, pPass = 0;
    bit finished = 0;
    for (int i = 0; i < 256; i++) begin seen[i] = 0; partOf[i] = -1; end
    @(negedge clk);
    sizeExp = NEXP_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 20000 && !finished; cyc++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = (rdyMode == 1) ? 1'b1 : (lfsr[1:0] != 2'b00);
      #1;
      if (prevStall) begin
        chk(outValid && int'(outAddr) == pAddr && int'(partIdx) == pPart &&
            int'(localOff) == pOff && int'(passNum) == pPass,
            "R8 stalled beat holds", int'(outAddr), pAddr);
      end
      if (done) begin
        chk(pass == expPass, "R3 pass count", pass, expPass);
        chk(!outValid, "R9 no valid after done", int'(outValid), 0);
        finished = 1;
      end else if (outValid && outReady) begin
        int ep = beat >> w;
        int eo = beat & ((1 << w) - 1);
        int ea = spread(n, m, ep, eo);
        chk(int'(passNum) == pass, "R3 pass number", int'(passNum), pass);
        chk(int'(stepFirst) == firstStep(n, pass), "R2 first step",
            int'(stepFirst), firstStep(n, pass));
        chk(int'(stepLast) == lastStep(n, pass), "R2 last step",
            int'(stepLast), lastStep(n, pass));
        chk(int'(partIdx) == ep && int'(localOff) == eo, "R6 beat order",
            int'(partIdx) * 1000 + int'(localOff), ep * 1000 + eo);
        chk(int'(outAddr) == ea, "R7 address composition", int'(outAddr), ea);
        chk(!seen[outAddr], "R4 address unique in pass", int'(outAddr), -1);
        seen[outAddr] = 1;
        partOf[outAddr] = int'(partIdx);
        beat++;
        if (beat == items) begin
          int cov = 0;
          int bad = 0;
          for (int i = 0; i < items; i++) if (seen[i]) cov++;
          chk(cov == items, "R4 pass covers all addresses", cov, items);
          for (int k = firstStep(n, pass); k <= lastStep(n, pass); k++)
            for (int r = 0; r < items; r++)
              if (partOf[r] != partOf[r ^ (1 << stepDist(k))]) bad++;
          chk(bad == 0, "R5 partners share partition", bad, 0);
          for (int i = 0; i < 256; i++) begin seen[i] = 0; partOf[i] = -1; end
          beat = 0;
          pass++;
          m = passMask(n, pass);
        end
      end
      prevStall = outValid && !outReady;
      pAddr = int'(outAddr); pPart = int'(partIdx);
      pOff = int'(localOff); pPass = int'(passNum);
    end
    chk(finished, "R9 run reaches done (watchdog)", int'(finished), 1);
    chk(done && !outValid, "R9 done held", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!outValid, "R1 reset valid", int'(outValid), 0);
    chk(!done, "R1 reset done", int'(done), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!outValid && !done, "R1 idle after reset", int'(outValid), 0);
    for (int v = 0; v < NRUN; v++) runOne(RUN_N[v], RUN_PASS[v], RUN_RDY[v]);
    // R9: done stays high with no start
    repeat (5) @(negedge clk);
    #1;
    chk(done && !outValid, "R9 done persists", int'(done), 1);
    // R7: single-pass case gives address equal to offset, directed
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(!done && !outValid, "R1 reset clears done", int'(done), 0);
    runOne(2, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule